// File: doc/BRIEF.md
# Power-Down Mode Sequencer with Settling Ready

This block turns three static power-control inputs into one of seven operating modes for a mixed-signal transceiver. For the selected mode it drives enables for the transmit modulator core, the shared reference and PLL, the high-impedance control of the I/Q output drivers, the receive demodulator core and the clock-recovery section. It also drives a level that clears the control register in the deepest shutdown mode. The analog switches that act on these enables are outside the block.

Every change of mode starts a settling interval whose length depends on what the change switches on. Powering the reference up takes longest. Powering the demodulator up takes less time, and powering the modulator up alone takes less again. Every other change uses a short minimum. A single ready output stays low while the interval counts down on the reference clock. If the inputs move again before the interval ends, the count starts over. The new length comes from the change between the mode being settled into and the newly requested mode.

Top module: `pdn_power_seq`

## Requirements
- R1: The control inputs decode as follows. When commMode=0: txPwr=1 selects OFF_CLR (rxPwr ignored), txPwr=0 with rxPwr=0 selects OFF_KEEP, and txPwr=0 with rxPwr=1 selects RX_ONLY. When commMode=1, the pair {rxPwr,txPwr} selects a mode: 00 selects CR_STBY, 01 selects TX_CR, 10 selects RX_STBY and 11 selects FULL.
- R2: regClear is 1 exactly while the current mode is OFF_CLR. OFF_KEEP has all rails off with regClear 0.
- R3: Enables per mode are {modEn,refEn,iqHiZ,demodEn,clkRecEn}: OFF_CLR=00000, OFF_KEEP=00000, RX_ONLY=00011, CR_STBY=01101, TX_CR=11001, RX_STBY=01111, FULL=11011. The enables follow the input values sampled at a rising edge, starting from that edge.
- R4: iqHiZ is 1 only in CR_STBY and RX_STBY, the modes that have the reference on and the modulator off.
- R5: A change that turns refEn from 0 to 1 holds ready low for LONG_CYC cycles, starting from the edge that samples the change.
- R6: A change that does not raise refEn but raises demodEn holds ready low for MID_CYC cycles.
- R7: A change that raises only modEn holds ready low for SHORT_CYC cycles.
- R8: Any other change of mode holds ready low for MIN_CYC cycles.
- R9: A change while ready is low restarts the count. The new length follows R5 to R8, applied from the mode being settled into to the new mode.
- R10: After reset the mode is OFF_CLR and ready is 1. Input values that decode to the current mode, including a toggle of rxPwr while in OFF_CLR, leave ready and all enables unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock for settling counts |
| rstN | input | 1 | Asynchronous active-low reset |
| commMode | input | 1 | 0 selects the standby group, 1 selects the communication group |
| txPwr | input | 1 | Transmit-side power request |
| rxPwr | input | 1 | Receive-side power request |
| modEn | output | 1 | Modulator core enable |
| refEn | output | 1 | Reference and PLL enable |
| iqHiZ | output | 1 | I/Q output drivers in high impedance |
| demodEn | output | 1 | Demodulator core enable |
| clkRecEn | output | 1 | Clock-recovery section enable |
| regClear | output | 1 | Control-register clear level |
| ready | output | 1 | High when no settling interval is running |

## Verification
The hardest case to reach is the restart. A second request has to arrive while a long count is still running, and the new length depends on the mode being settled into, not on the mode last settled. The stimulus leaves the receive-only mode for a reference-on mode, which starts a long count. It changes again partway through that count, so that only the modulator rises and the short length should apply. It also leaves full power after a few cycles, which tests the minimum length. A toggle of the ignored input in the clearing mode confirms that an input move that keeps the same mode starts no count.

// File: rtl/pdn_pkg.sv
package pdn_pkg;

  typedef enum logic [2:0] {
    OFF_CLR  = 3'd0,
    OFF_KEEP = 3'd1,
    RX_ONLY  = 3'd2,
    CR_STBY  = 3'd3,
    TX_CR    = 3'd4,
    RX_STBY  = 3'd5,
    FULL     = 3'd6
  } pwrMode_t;

  typedef struct packed {
    logic modEn;
    logic refEn;
    logic iqHiZ;
    logic demodEn;
    logic clkRecEn;
  } railEn_t;

  typedef enum logic [1:0] {
    SETTLE_MIN   = 2'd0,
    SETTLE_SHORT = 2'd1,
    SETTLE_MID   = 2'd2,
    SETTLE_LONG  = 2'd3
  } settleSel_t;

  typedef struct packed {
    logic       load;
    settleSel_t sel;
  } settleStb_t;

  function automatic pwrMode_t decodeMode(input logic comm, input logic tx, input logic rx);
    pwrMode_t m;
    if (!comm) begin
      if (tx)      m = OFF_CLR;
      else if (rx) m = RX_ONLY;
      else         m = OFF_KEEP;
    end else begin
      case ({rx, tx})
        2'b00:   m = CR_STBY;
        2'b01:   m = TX_CR;
        2'b10:   m = RX_STBY;
        default: m = FULL;
      endcase
    end
    return m;
  endfunction

  function automatic railEn_t railsFor(input pwrMode_t m);
    railEn_t r;
    case (m)
      RX_ONLY: r = 5'b00011;
      CR_STBY: r = 5'b01101;
      TX_CR:   r = 5'b11001;
      RX_STBY: r = 5'b01111;
      FULL:    r = 5'b11011;
      default: r = 5'b00000;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/pdn_mode_ctrl.sv
module pdn_mode_ctrl
  import pdn_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       commMode,
  input  logic       txPwr,
  input  logic       rxPwr,
  output railEn_t    rails,
  output logic       regClear,
  output settleStb_t stb
);

  pwrMode_t curMode;
  pwrMode_t nextMode;
  railEn_t  nextRails;
  logic     modeChange;

  always_comb begin
    nextMode   = decodeMode(commMode, txPwr, rxPwr);
    nextRails  = railsFor(nextMode);
    modeChange = (nextMode != curMode);
  end

  // Settling length picked from the rails that the change switches on
  always_comb begin
    stb.load = modeChange;
    if (!rails.refEn && nextRails.refEn)          stb.sel = SETTLE_LONG;
    else if (!rails.demodEn && nextRails.demodEn) stb.sel = SETTLE_MID;
    else if (!rails.modEn && nextRails.modEn)     stb.sel = SETTLE_SHORT;
    else                                          stb.sel = SETTLE_MIN;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) curMode <= OFF_CLR;
    else if (modeChange) curMode <= nextMode;
  end

  assign rails    = railsFor(curMode);
  assign regClear = (curMode == OFF_CLR);

  // R2: the clearing mode never has a rail on
  a_r2_clear_all_off: assert property (@(posedge clk) disable iff (!rstN)
    regClear |-> (rails == '0));

  // R4: drivers parked only with reference up and modulator down
  a_r4_hiz_ref_only: assert property (@(posedge clk) disable iff (!rstN)
    rails.iqHiZ |-> (rails.refEn && !rails.modEn));

  // R10: rails move only on a detected mode change
  a_r10_rails_hold: assert property (@(posedge clk) disable iff (!rstN)
    !stb.load |=> $stable(rails));

endmodule

// File: rtl/pdn_settle_count.sv
module pdn_settle_count
  import pdn_pkg::*;
#(
  parameter int LONG_CYC  = 19200,
  parameter int MID_CYC   = 768,
  parameter int SHORT_CYC = 96,
  parameter int MIN_CYC   = 19
) (
  input  logic       clk,
  input  logic       rstN,
  input  settleStb_t stb,
  output logic       ready
);

  localparam int CW = $clog2(LONG_CYC + 1);

  logic [CW-1:0] count;
  logic [CW-1:0] loadVal;

  always_comb begin
    case (stb.sel)
      SETTLE_LONG:  loadVal = CW'(LONG_CYC);
      SETTLE_MID:   loadVal = CW'(MID_CYC);
      SETTLE_SHORT: loadVal = CW'(SHORT_CYC);
      default:      loadVal = CW'(MIN_CYC);
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             count <= '0;
    else if (stb.load)     count <= loadVal;
    else if (count != '0)  count <= count - 1'b1;
  end

  assign ready = (count == '0);

  // R8: a running interval shrinks by one each cycle when not reloaded
  a_r8_count_down: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.load && count != '0) |=> (count == $past(count) - 1'b1));

  // R9: a reload always drops ready on the next cycle
  a_r9_reload_low: assert property (@(posedge clk) disable iff (!rstN)
    stb.load |=> !ready);

  // R10: ready stays up while nothing is requested
  a_r10_ready_holds: assert property (@(posedge clk) disable iff (!rstN)
    (ready && !stb.load) |=> ready);

endmodule

// File: rtl/pdn_power_seq.sv
module pdn_power_seq
  import pdn_pkg::*;
#(
  parameter int LONG_CYC  = 19200,
  parameter int MID_CYC   = 768,
  parameter int SHORT_CYC = 96,
  parameter int MIN_CYC   = 19
) (
  input  logic clk,
  input  logic rstN,
  input  logic commMode,
  input  logic txPwr,
  input  logic rxPwr,
  output logic modEn,
  output logic refEn,
  output logic iqHiZ,
  output logic demodEn,
  output logic clkRecEn,
  output logic regClear,
  output logic ready
);

  railEn_t    rails;
  settleStb_t stb;

  pdn_mode_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .commMode(commMode), .txPwr(txPwr), .rxPwr(rxPwr),
    .rails(rails), .regClear(regClear), .stb(stb)
  );

  pdn_settle_count #(
    .LONG_CYC(LONG_CYC), .MID_CYC(MID_CYC), .SHORT_CYC(SHORT_CYC), .MIN_CYC(MIN_CYC)
  ) u_count (
    .clk(clk), .rstN(rstN), .stb(stb), .ready(ready)
  );

  assign modEn    = rails.modEn;
  assign refEn    = rails.refEn;
  assign iqHiZ    = rails.iqHiZ;
  assign demodEn  = rails.demodEn;
  assign clkRecEn = rails.clkRecEn;

  // R5: a fresh reference power-up is never reported ready at once
  a_r5_ref_rise_waits: assert property (@(posedge clk) disable iff (!rstN)
    $rose(refEn) |-> !ready);

endmodule

// File: tb/pdn_power_seq_test.sv
module pdn_power_seq_test;

  localparam int L = 40, M = 20, S = 8, N = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic commMode = 1'b0, txPwr = 1'b1, rxPwr = 1'b0;
  logic modEn, refEn, iqHiZ, demodEn, clkRecEn, regClear, ready;

  always #2.5 clk = ~clk;

  pdn_power_seq #(.LONG_CYC(L), .MID_CYC(M), .SHORT_CYC(S), .MIN_CYC(N)) uut (
    .clk(clk), .rstN(rstN), .commMode(commMode), .txPwr(txPwr), .rxPwr(rxPwr),
    .modEn(modEn), .refEn(refEn), .iqHiZ(iqHiZ), .demodEn(demodEn),
    .clkRecEn(clkRecEn), .regClear(regClear), .ready(ready)
  );

  int vectors = 0, errs = 0, cycles = 0;
  int mMode = 0, rem = 0;
  string rTag = "R10";

  // mode index: 0 clear,1 keep,2 rx-only,3 cr-stby,4 tx-cr,5 rx-stby,6 full
  function automatic int modelDecode(logic c, logic t, logic r);
    if (!c) return t ? 0 : (r ? 2 : 1);
    if (!r && !t) return 3;
    if (!r && t) return 4;
    if (r && !t) return 5;
    return 6;
  endfunction

  // bits: mod, ref, hiz, demod, clkrec
  function automatic logic [4:0] modelRails(int m);
    logic [4:0] t [7] = '{5'b00000, 5'b00000, 5'b00011, 5'b01101, 5'b11001, 5'b01111, 5'b11011};
    return t[m];
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mMode = 0; rem = 0; rTag = "R10";
    end else begin
      cycles++;
      begin
        int nm;
        logic [4:0] p, q;
        nm = modelDecode(commMode, txPwr, rxPwr);
        if (nm != mMode) begin
          p = modelRails(mMode); q = modelRails(nm);
          if (rem > 0)               rTag = "R9";
          else if (!p[3] && q[3])    rTag = "R5";
          else if (!p[1] && q[1])    rTag = "R6";
          else if (!p[4] && q[4])    rTag = "R7";
          else                       rTag = "R8";
          if (!p[3] && q[3])         rem = L;
          else if (!p[1] && q[1])    rem = M;
          else if (!p[4] && q[4])    rem = S;
          else                       rem = N;
          mMode = nm;
        end else if (rem > 0) rem--;
      end
      if (cycles > 20000) begin
        errs++;
        $display("FAIL watchdog expired: actual %0d cycles, expected under 20000", cycles);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
        $finish;
      end
    end
  end

  task automatic compare();
    logic [4:0] exp, act;
    exp = modelRails(mMode);
    act = {modEn, refEn, iqHiZ, demodEn, clkRecEn};
    vectors++;
    if ({act[4], act[3], act[1], act[0]} !== {exp[4], exp[3], exp[1], exp[0]}) begin
      errs++;
      $display("FAIL R1/R3 mode %0d rails: actual %b expected %b", mMode, act, exp);
    end
    if (act[2] !== exp[2]) begin
      errs++;
      $display("FAIL R4 mode %0d iqHiZ: actual %b expected %b", mMode, act[2], exp[2]);
    end
    if (regClear !== (mMode == 0)) begin
      errs++;
      $display("FAIL R2 regClear: actual %b expected %b", regClear, mMode == 0);
    end
    if (ready !== (rem == 0)) begin
      errs++;
      $display("FAIL %s ready: actual %b expected %b (remaining %0d)", rTag, ready, rem == 0, rem);
    end
  endtask

  task automatic hold(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare();
    end
  endtask

  task automatic req(logic c, logic t, logic r, int n);
    @(negedge clk);
    compare();
    commMode = c; txPwr = t; rxPwr = r;
    hold(n);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    compare();                 // R10 reset state while held
    rstN = 1'b1;
    hold(4);                   // R10 idle in clearing mode
    req(1, 1, 1, 50);          // R5 full power from clear
    req(1, 0, 0, 10);          // R8 down to cr-stby
    req(1, 1, 0, 15);          // R7 modulator only
    req(1, 1, 1, 25);          // R6 demod rises
    req(0, 0, 0, 6);           // R8 keep-off
    req(0, 0, 1, 25);          // R6 demod with reference off
    req(1, 0, 1, 10);          // R5 long start, cut short
    req(1, 1, 1, 15);          // R9 restart: only modulator rises
    req(0, 1, 0, 5);           // R2 clear mode
    req(0, 1, 1, 6);           // R10 rxPwr ignored in clear mode
    req(1, 1, 1, 5);           // R5 start long
    req(0, 0, 0, 8);           // R9 restart with minimum
    req(1, 0, 1, 45);          // R5 again from keep-off
    rstN = 1'b0;
    hold(2);                   // R10 asynchronous reset mid-run
    commMode = 0; txPwr = 1; rxPwr = 0;
    rstN = 1'b1;
    hold(4);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end

endmodule